// File: doc/BRIEF.md
# CAN FD Transmitter Delay Compensator

This block supports bit checking in the fast data phase of a CAN FD frame. Once per frame, during a window flagged by the frame logic, it times the loop from the transmit pin back to the receive pin. It counts CAN clock cycles from a falling edge on the transmitted stream to the matching falling edge on the received stream, and keeps the result as a 6-bit value.

During the data phase, every data bit start launches a position counter. When the counter reaches the secondary sample point, the block emits a one-cycle strobe. With compensation enabled, that point is the measured delay plus a programmable offset. With compensation disabled, it is the ordinary data-phase sample point.

The block also computes the largest delay the data-phase timing can tolerate. A sticky failure flag is raised if a measurement exceeds this limit or the counter saturates.

Top module: `fd_txdelay_comp`

## Requirements
- R1: After reset, `tdc_value` is 0, `tdc_fail` is 0 and `ssp_strobe` is 0.
- R2: While `meas_arm` is high and no measurement has yet completed in the current arm window, a high-to-low change of `tx_bit` starts a measurement. If `rx_bit` falls d cycles later (d = 0 when both fall on the same edge), `tdc_value` becomes d. The new value appears one cycle after the clock edge that samples the fall of `rx_bit`.
- R3: If `rx_bit` has not fallen by the point where the count would reach 63, the measurement ends with `tdc_value` = 63 and `tdc_fail` set.
- R4: The limit in clock cycles is L = (data_psc+1) × (3 × (3 + data_prop + data_seg1 + data_seg2) − 2). A result greater than L sets `tdc_fail` one cycle after `tdc_value` updates. A result equal to L does not set it.
- R5: A fall of `tx_bit` is ignored while `meas_arm` is low. It is also ignored after a measurement has completed in the same arm window, so `tdc_value` keeps its value.
- R6: `tdc_fail` stays set until cleared. A `fail_clr` pulse clears it on the next cycle, unless a new failure is set on the same edge.
- R7: `cfg_mode` clears `tdc_fail` and aborts a measurement in progress. `tdc_value` is kept unchanged.
- R8: With `comp_en` = 1 and `data_phase` = 1, `ssp_strobe` rises P + 1 cycles after the clock edge that samples `dbit_start`, where P = `tdc_value` + `ssp_offset`.
- R9: With `comp_en` = 0, the same timing applies with P = (data_psc+1) × (2 + data_prop + data_seg1).
- R10: `dbit_start` is ignored while `data_phase` is low. A low `data_phase` also cancels a pending strobe.
- R11: A new `dbit_start` restarts the position count, so only the strobe due from the latest bit start appears.
- R12: `ssp_strobe` is high for exactly one cycle per bit start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CAN clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 1 | Configuration mode; clears the flag and aborts a measurement |
| fail_clr | input | 1 | Write-one clear of `tdc_fail` |
| comp_en | input | 1 | 1 = delay-compensated sample point, 0 = normal sample point |
| data_psc | input | 10 | Data-phase prescaler; time quantum = value+1 clocks |
| data_seg1 | input | 3 | Data phase segment 1 minus one, in quanta |
| data_seg2 | input | 3 | Data phase segment 2 minus one, in quanta |
| data_prop | input | 5 | Data propagation segment, in quanta |
| ssp_offset | input | 5 | Offset added to the measured delay, in clocks |
| meas_arm | input | 1 | High around the bit where the delay is measured |
| tx_bit | input | 1 | Transmitted bit stream |
| rx_bit | input | 1 | Received bit stream |
| data_phase | input | 1 | High while the frame is in its data phase |
| dbit_start | input | 1 | One-cycle pulse at the start of each data bit |
| tdc_value | output | 6 | Measured delay in clocks |
| ssp_strobe | output | 1 | Secondary sample point strobe |
| tdc_fail | output | 1 | Sticky flag: compensation impossible |

## Verification
Each result has a fixed delay from its stimulus. `tdc_value` changes one cycle after the edge that samples the receive fall, or the saturation point, which is the tx-fall cycle plus the delay plus one. `tdc_fail` follows one cycle later. `ssp_strobe` appears at the bit-start drive cycle plus P plus two. For every stimulus, the driver pushes the expected value together with that exact cycle number into a queue. A monitor compares outputs at the falling clock edge, only on the listed cycles. Strobe checks also probe the cycles on either side, so early, late and stretched pulses are all caught.

// File: rtl/fdtdc_pkg.sv
package fdtdc_pkg;

    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_RUN  = 2'd1,
        MS_HELD = 2'd2
    } meas_st_e;

    function automatic logic fell(input logic prev, input logic now);
        return prev & ~now;
    endfunction

endpackage

// File: rtl/fdtdc_meter.sv
module fdtdc_meter
    import fdtdc_pkg::*;
#(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode,
    input  logic             arm,
    input  logic             tx,
    input  logic             rx,
    output logic [DLY_W-1:0] dly,
    output logic             done,
    output logic             sat
);
    localparam logic [DLY_W-1:0] DLY_MAX = {DLY_W{1'b1}};

    typedef struct packed {
        meas_st_e         st;
        logic             tx_q;
        logic             rx_q;
        logic [DLY_W-1:0] cnt;
        logic [DLY_W-1:0] dly;
        logic             done;
        logic             sat;
    } mstate_t;

    mstate_t s_q, s_d;
    logic tx_fall, rx_fall;
    logic [DLY_W-1:0] cnt_inc;

    always_comb begin
        tx_fall = fell(s_q.tx_q, tx);
        rx_fall = fell(s_q.rx_q, rx);
        cnt_inc = s_q.cnt + 1'b1;
        s_d      = s_q;
        s_d.tx_q = tx;
        s_d.rx_q = rx;
        s_d.done = 1'b0;
        s_d.sat  = 1'b0;
        if (cfg_mode) begin
            s_d.st  = MS_IDLE;
            s_d.cnt = '0;
        end else begin
            unique case (s_q.st)
                MS_IDLE: begin
                    if (arm && tx_fall) begin
                        if (rx_fall) begin
                            s_d.dly  = '0;
                            s_d.done = 1'b1;
                            s_d.st   = MS_HELD;
                        end else begin
                            s_d.cnt = '0;
                            s_d.st  = MS_RUN;
                        end
                    end
                end
                MS_RUN: begin
                    if (rx_fall) begin
                        s_d.dly  = cnt_inc;
                        s_d.done = 1'b1;
                        s_d.st   = MS_HELD;
                    end else if (cnt_inc == DLY_MAX) begin
                        s_d.dly  = DLY_MAX;
                        s_d.done = 1'b1;
                        s_d.sat  = 1'b1;
                        s_d.st   = MS_HELD;
                    end else begin
                        s_d.cnt = cnt_inc;
                    end
                end
                MS_HELD: begin
                    if (!arm) s_d.st = MS_IDLE;
                end
                default: s_d.st = MS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= MS_IDLE;
            s_q.tx_q <= 1'b1;
            s_q.rx_q <= 1'b1;
            s_q.cnt  <= '0;
            s_q.dly  <= '0;
            s_q.done <= 1'b0;
            s_q.sat  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dly  = s_q.dly;
    assign done = s_q.done;
    assign sat  = s_q.sat;

endmodule

// File: rtl/fdtdc_limit.sv
module fdtdc_limit #(
    parameter int PSC_W  = 10,
    parameter int SEG_W  = 3,
    parameter int PROP_W = 5,
    parameter int LIM_W  = 20
) (
    input  logic [PSC_W-1:0]  psc,
    input  logic [SEG_W-1:0]  seg1,
    input  logic [SEG_W-1:0]  seg2,
    input  logic [PROP_W-1:0] prop,
    output logic [LIM_W-1:0]  limit,
    output logic [LIM_W-1:0]  nsp
);
    logic [LIM_W-1:0] tq_clk;
    logic [LIM_W-1:0] bit_tq;
    logic [LIM_W-1:0] sp_tq;

    always_comb begin
        tq_clk = LIM_W'(psc) + LIM_W'(1);
        bit_tq = LIM_W'(3) + LIM_W'(prop) + LIM_W'(seg1) + LIM_W'(seg2);
        sp_tq  = LIM_W'(2) + LIM_W'(prop) + LIM_W'(seg1);
        limit  = tq_clk * (LIM_W'(3) * bit_tq - LIM_W'(2));
        nsp    = tq_clk * sp_tq;
    end

endmodule

// File: rtl/fdtdc_ssp.sv
module fdtdc_ssp #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_phase,
    input  logic             bit_start,
    input  logic [CNT_W-1:0] target,
    output logic             strobe
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] pcnt;
        logic             stb;
    } sstate_t;

    sstate_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        s_d.stb = 1'b0;
        if (!data_phase) begin
            s_d.active = 1'b0;
            s_d.pcnt   = '0;
        end else if (bit_start) begin
            s_d.active = 1'b1;
            s_d.pcnt   = '0;
        end else if (s_q.active) begin
            if (s_q.pcnt == target) begin
                s_d.stb    = 1'b1;
                s_d.active = 1'b0;
            end else begin
                s_d.pcnt = s_q.pcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign strobe = s_q.stb;

endmodule

// File: rtl/fd_txdelay_comp.sv
module fd_txdelay_comp #(
    parameter int PSC_W  = 10,
    parameter int SEG_W  = 3,
    parameter int PROP_W = 5,
    parameter int OFS_W  = 5,
    parameter int DLY_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic              fail_clr,
    input  logic              comp_en,
    input  logic [PSC_W-1:0]  data_psc,
    input  logic [SEG_W-1:0]  data_seg1,
    input  logic [SEG_W-1:0]  data_seg2,
    input  logic [PROP_W-1:0] data_prop,
    input  logic [OFS_W-1:0]  ssp_offset,
    input  logic              meas_arm,
    input  logic              tx_bit,
    input  logic              rx_bit,
    input  logic              data_phase,
    input  logic              dbit_start,
    output logic [DLY_W-1:0]  tdc_value,
    output logic              ssp_strobe,
    output logic              tdc_fail
);
    localparam int TQ_W  = PSC_W + 1;
    localparam int BT_W  = ((PROP_W > SEG_W) ? PROP_W : SEG_W) + 2;
    localparam int LIM_W = TQ_W + BT_W + 2;
    localparam int CNT_W = (LIM_W > DLY_W + 1) ? LIM_W : DLY_W + 1;

    typedef struct packed {
        logic fail;
    } fstate_t;

    logic [DLY_W-1:0] meas_dly;
    logic             meas_done;
    logic             meas_sat;
    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] nsp;
    logic [CNT_W-1:0] ssp_tgt;
    fstate_t          f_q, f_d;

    fdtdc_meter #(.DLY_W(DLY_W)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_mode (cfg_mode),
        .arm      (meas_arm),
        .tx       (tx_bit),
        .rx       (rx_bit),
        .dly      (meas_dly),
        .done     (meas_done),
        .sat      (meas_sat)
    );

    fdtdc_limit #(
        .PSC_W  (PSC_W),
        .SEG_W  (SEG_W),
        .PROP_W (PROP_W),
        .LIM_W  (LIM_W)
    ) u_limit (
        .psc   (data_psc),
        .seg1  (data_seg1),
        .seg2  (data_seg2),
        .prop  (data_prop),
        .limit (limit),
        .nsp   (nsp)
    );

    always_comb begin
        if (comp_en) ssp_tgt = CNT_W'(meas_dly) + CNT_W'(ssp_offset);
        else         ssp_tgt = CNT_W'(nsp);
    end

    fdtdc_ssp #(.CNT_W(CNT_W)) u_ssp (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_phase (data_phase),
        .bit_start  (dbit_start),
        .target     (ssp_tgt),
        .strobe     (ssp_strobe)
    );

    always_comb begin
        f_d = f_q;
        if (cfg_mode) begin
            f_d.fail = 1'b0;
        end else if (meas_done && (meas_sat || (LIM_W'(meas_dly) > limit))) begin
            f_d.fail = 1'b1;
        end else if (fail_clr) begin
            f_d.fail = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign tdc_value = meas_dly;
    assign tdc_fail  = f_q.fail;

endmodule

// File: rtl/fd_txdelay_comp_chk.sv
module fd_txdelay_comp_chk #(
    parameter int DLY_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_mode,
    input logic             fail_clr,
    input logic             data_phase,
    input logic [DLY_W-1:0] tdc_value,
    input logic             ssp_strobe,
    input logic             tdc_fail
);
    // R6
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tdc_fail && !fail_clr && !cfg_mode) |=> tdc_fail);

    // R7
    cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode |=> !tdc_fail);

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode |=> $stable(tdc_value));

    // R7
    fail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tdc_fail) |-> !$past(cfg_mode));

    // R12
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ssp_strobe |=> !ssp_strobe);

    // R10
    phase_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_phase |=> !ssp_strobe);

endmodule

bind fd_txdelay_comp fd_txdelay_comp_chk #(.DLY_W(DLY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mode   (cfg_mode),
    .fail_clr   (fail_clr),
    .data_phase (data_phase),
    .tdc_value  (tdc_value),
    .ssp_strobe (ssp_strobe),
    .tdc_fail   (tdc_fail)
);

// File: tb/sim_fd_txdelay_comp.sv
`timescale 1ns/1ps
module sim_fd_txdelay_comp;
    logic       clk = 1'b0;
    logic       rst_n, cfg_mode, fail_clr, comp_en;
    logic [9:0] data_psc;
    logic [2:0] data_seg1, data_seg2;
    logic [4:0] data_prop, ssp_offset;
    logic       meas_arm, tx_bit, rx_bit, data_phase, dbit_start;
    logic [5:0] tdc_value;
    logic       ssp_strobe, tdc_fail;

    always #5 clk = ~clk;

    fd_txdelay_comp u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .fail_clr(fail_clr),
        .comp_en(comp_en), .data_psc(data_psc), .data_seg1(data_seg1),
        .data_seg2(data_seg2), .data_prop(data_prop), .ssp_offset(ssp_offset),
        .meas_arm(meas_arm), .tx_bit(tx_bit), .rx_bit(rx_bit),
        .data_phase(data_phase), .dbit_start(dbit_start),
        .tdc_value(tdc_value), .ssp_strobe(ssp_strobe), .tdc_fail(tdc_fail)
    );

    typedef struct {
        int    cyc;
        int    sig;
        int    exp;
        string tag;
    } item_t;

    item_t sbq[$];
    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int m_dly = 0;
    int m_fail = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sig_val(input int s);
        case (s)
            0:       return int'(tdc_value);
            1:       return int'(tdc_fail);
            default: return int'(ssp_strobe);
        endcase
    endfunction

    // monitor: compares the items due on this cycle
    always @(negedge clk) begin
        item_t keep[$];
        keep = {};
        foreach (sbq[i]) begin
            if (sbq[i].cyc == cyc) begin
                n_chk++;
                if (sig_val(sbq[i].sig) != sbq[i].exp) begin
                    n_bad++;
                    $display("FAIL %s sig%0d cycle %0d actual=%0d expected=%0d",
                             sbq[i].tag, sbq[i].sig, cyc, sig_val(sbq[i].sig), sbq[i].exp);
                end
            end else begin
                keep.push_back(sbq[i]);
            end
        end
        sbq = keep;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(input int dt, input int s, input int v, input string tag);
        item_t it;
        it.cyc = cyc + dt;
        it.sig = s;
        it.exp = v;
        it.tag = tag;
        sbq.push_back(it);
    endtask

    function automatic int lim_f();
        return (int'(data_psc) + 1) *
               (3 * (3 + int'(data_prop) + int'(data_seg1) + int'(data_seg2)) - 2);
    endfunction

    task automatic measure(input int d, input string tag);
        int dv;
        meas_arm = 1'b1;
        step(1);
        tx_bit = 1'b0;
        if (d == 0) rx_bit = 1'b0;
        dv = (d > 63) ? 63 : d;
        m_dly = dv;
        if (d > 63 || dv > lim_f()) m_fail = 1;
        expect_at(dv + 1, 0, dv, tag);
        expect_at(dv + 2, 1, m_fail, tag);
        if (d > 0) begin
            step(d);
            rx_bit = 1'b0;
        end
        step(3);
        tx_bit = 1'b1;
        rx_bit = 1'b1;
        meas_arm = 1'b0;
        step(2);
    endtask

    task automatic ssp_probe(input int p, input string tag);
        dbit_start = 1'b1;
        expect_at(p + 1, 2, 0, tag);
        expect_at(p + 2, 2, 1, tag);
        expect_at(p + 3, 2, 0, "R12");
        step(1);
        dbit_start = 1'b0;
        step(p + 5);
    endtask

    initial begin
        rst_n = 1'b0; cfg_mode = 1'b0; fail_clr = 1'b0; comp_en = 1'b0;
        data_psc = 10'd0; data_seg1 = 3'd1; data_seg2 = 3'd1; data_prop = 5'd1;
        ssp_offset = 5'd3; meas_arm = 1'b0; tx_bit = 1'b1; rx_bit = 1'b1;
        data_phase = 1'b0; dbit_start = 1'b0;
        step(3);
        rst_n = 1'b1;
        expect_at(1, 0, 0, "R1");
        expect_at(1, 1, 0, "R1");
        expect_at(1, 2, 0, "R1");
        step(3);

        // R2 delay measurement, including the zero case
        measure(5, "R2");
        measure(0, "R2");
        // R4 limit boundary: L = 16 with this setting
        measure(16, "R4");
        measure(17, "R4");
        // R6 sticky, then cleared
        step(4);
        expect_at(1, 1, 1, "R6");
        step(2);
        fail_clr = 1'b1;
        m_fail = 0;
        expect_at(1, 1, 0, "R6");
        step(1);
        fail_clr = 1'b0;
        step(2);

        // R4 prescaler scales the limit: L = 64
        data_psc = 10'd3;
        measure(40, "R4");
        // R3 saturation
        measure(70, "R3");

        // R7 configuration mode clears flag, keeps value
        cfg_mode = 1'b1;
        m_fail = 0;
        expect_at(1, 1, 0, "R7");
        expect_at(1, 0, m_dly, "R7");
        step(1);
        cfg_mode = 1'b0;
        step(2);

        // R5 tx fall with arm low ignored
        tx_bit = 1'b0;
        step(4);
        rx_bit = 1'b0;
        step(2);
        expect_at(1, 0, m_dly, "R5");
        step(2);
        tx_bit = 1'b1;
        rx_bit = 1'b1;
        step(2);

        // R5 only the first fall in an arm window is measured
        meas_arm = 1'b1;
        step(1);
        tx_bit = 1'b0;
        m_dly = 4;
        expect_at(5, 0, 4, "R5");
        step(4);
        rx_bit = 1'b0;
        step(2);
        tx_bit = 1'b1;
        rx_bit = 1'b1;
        step(2);
        tx_bit = 1'b0;
        step(9);
        rx_bit = 1'b0;
        step(2);
        expect_at(1, 0, 4, "R5");
        step(2);
        tx_bit = 1'b1;
        rx_bit = 1'b1;
        meas_arm = 1'b0;
        step(2);

        // R7 abort a running measurement
        meas_arm = 1'b1;
        step(1);
        tx_bit = 1'b0;
        step(3);
        cfg_mode = 1'b1;
        step(1);
        cfg_mode = 1'b0;
        step(3);
        rx_bit = 1'b0;
        step(2);
        expect_at(1, 0, 4, "R7");
        expect_at(1, 1, 0, "R7");
        step(2);
        tx_bit = 1'b1;
        rx_bit = 1'b1;
        meas_arm = 1'b0;
        step(2);

        // R8 compensated strobe: P = 4 + 3
        data_phase = 1'b1;
        comp_en = 1'b1;
        step(1);
        ssp_probe(7, "R8");
        ssp_offset = 5'd10;
        ssp_probe(14, "R8");
        ssp_offset = 5'd3;

        // R9 normal sample point: (3+1) * (2+1+1) = 16, then 4
        comp_en = 1'b0;
        ssp_probe(16, "R9");
        data_psc = 10'd0;
        ssp_probe(4, "R9");

        // R10 bit start ignored outside the data phase
        data_phase = 1'b0;
        dbit_start = 1'b1;
        expect_at(6, 2, 0, "R10");
        step(1);
        dbit_start = 1'b0;
        step(8);
        // R10 pending strobe cancelled
        data_phase = 1'b1;
        step(1);
        dbit_start = 1'b1;
        expect_at(6, 2, 0, "R10");
        step(1);
        dbit_start = 1'b0;
        step(1);
        data_phase = 1'b0;
        step(8);

        // R11 restart: P = 7
        data_phase = 1'b1;
        comp_en = 1'b1;
        step(1);
        dbit_start = 1'b1;
        expect_at(9, 2, 0, "R11");
        step(1);
        dbit_start = 1'b0;
        step(2);
        dbit_start = 1'b1;
        expect_at(9, 2, 1, "R11");
        expect_at(10, 2, 0, "R12");
        step(1);
        dbit_start = 1'b0;
        step(14);

        step(3);
        if (sbq.size() != 0) begin
            n_bad += sbq.size();
            $display("FAIL scoreboard: %0d items never compared, expected 0", sbq.size());
        end
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule